// File: doc/BRIEF.md
# Rule-Scheduled Increment/Branch Pipeline

This block is a small three-stage pipelined processor whose control is derived from per-stage firing conditions evaluated together in every clock cycle. A fetch stage presents the program counter on an instruction-memory address port and captures the returned word into a one-entry instruction queue. An operand stage reads the register file and forwards the instruction, together with its operand value, into a one-entry operand queue. A resolve stage either writes an incremented value back or acts on a jump-if-zero.

Each queue is a presence bit plus a payload register. A stage may push into a full queue when the stage behind it drains that queue in the same cycle, so straight-line code flows at one instruction per cycle. An operand read stalls only when the operand queue holds an increment to the same register. A taken jump reloads the program counter and empties both queues, and it overrides every other update in that cycle. A combinational debug port reads any register, and the program's final register contents match a one-instruction-at-a-time execution of the same program.

Top module: `rsp_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter to 0, empties both queues and clears every register to 0.
- R2: An instruction word is 11 bits: bit 10 selects the kind (0 = increment, 1 = jump-if-zero), bits 9:8 name one of four registers and bits 7:0 hold the jump target.
- R3: `imem_addr` always shows the program counter; whenever the fetch stage appends the word read at that address, the program counter advances by one in the next cycle.
- R4: An increment that reaches the resolve stage writes its register's value plus one, wrapping modulo 256, and the result is visible on the debug port after that clock edge.
- R5: An instruction at the head of the instruction queue that names the same register as an increment held in the operand queue stays in the instruction queue for that cycle, and fetch holds too; it then reads the written-back value.
- R6: A jump-if-zero whose operand value is nonzero has no effect beyond leaving the pipeline; the next sequential instruction executes.
- R7: A jump-if-zero whose operand value is zero loads the program counter with its target and empties both queues in the same edge, overriding any fetch or operand append in that cycle; instructions fetched after the jump never execute, and fetch resumes at the target in the following cycle.
- R8: Each queue accepts a new entry in a cycle where it is full but drained by the next stage, so independent straight-line code advances the program counter every cycle.
- R9: `dbg_val` combinationally shows the register selected by `dbg_sel`.
- R10: After a program settles, the register file equals the result of executing the same program one instruction at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction-memory address (program counter) |
| imem_data | input | 11 | Instruction word at `imem_addr`, combinational |
| dbg_sel | input | 2 | Register selected for debug read |
| dbg_val | output | 8 | Value of the selected register |

## Verification
The hardest situations to reach from the ports are the exact cycle in which a same-register stall holds fetch, and a taken jump that must discard instructions already fetched behind it. Short directed programs put an increment directly behind another increment to the same register, and put a jump on an always-zero register ahead of increments that must never land. The address port is sampled edge by edge to show the stall cycle, the single-cycle redirect and the full-rate flow. A counted loop that exits on an 8-bit wrap then checks the settled registers against a sequential reference run.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int DATA_W  = 8;
    localparam int PC_W    = 8;
    localparam int NREG    = 4;
    localparam int IDX_W   = $clog2(NREG);
    localparam int INSTR_W = 1 + IDX_W + PC_W;

    typedef enum logic {
        OP_INC = 1'b0,
        OP_JZ  = 1'b1
    } op_e;

    // fetched instruction, as held in the instruction queue
    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] idx;
        logic [PC_W-1:0]  label;
    } instr_t;

    // instruction with operand value, as held in the operand queue
    typedef struct packed {
        op_e               op;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] val;
        logic [PC_W-1:0]   label;
    } opnd_t;

    function automatic instr_t unpack_word(logic [INSTR_W-1:0] w);
        return instr_t'(w);
    endfunction

    // read-after-write conflict with an increment still waiting to resolve
    function automatic logic raw_pending(instr_t head, logic pend_v, opnd_t pend);
        return pend_v && (pend.op == OP_INC) && (pend.idx == head.idx);
    endfunction

    function automatic opnd_t attach_value(instr_t head, logic [DATA_W-1:0] v);
        opnd_t o;
        o.op    = head.op;
        o.idx   = head.idx;
        o.val   = v;
        o.label = head.label;
        return o;
    endfunction

endpackage

// File: rtl/rsp_regfile.sv
module rsp_regfile
    import rsp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_val,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [DATA_W-1:0]           rd_val,
    input  logic [IDX_W-1:0]            dbg_idx,
    output logic [DATA_W-1:0]           dbg_val,
    output logic [NREG-1:0][DATA_W-1:0] regs_o
);

    logic [NREG-1:0][DATA_W-1:0] cells;

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                cells[g] <= wr_val;
            end
        end
    end

    assign rd_val  = cells[rd_idx];
    assign dbg_val = cells[dbg_idx];
    assign regs_o  = cells;

endmodule

// File: rtl/rsp_fetch.sv
module rsp_fetch
    import rsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               deq,
    input  logic               redirect,
    input  logic [PC_W-1:0]    target,
    input  logic [INSTR_W-1:0] word,
    output logic [PC_W-1:0]    pc,
    output logic               iq_v,
    output instr_t             iq_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            iq_v <= 1'b0;
            iq_q <= '0;
        end else if (redirect) begin
            // a taken jump beats any append in the same cycle
            pc   <= target;
            iq_v <= 1'b0;
        end else if (fire) begin
            pc   <= pc + PC_W'(1);
            iq_v <= 1'b1;
            iq_q <= unpack_word(word);
        end else if (deq) begin
            iq_v <= 1'b0;
        end
    end

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !redirect) |=> (pc == $past(pc) + PC_W'(1)));

    // R8
    refill_chk: assert property (@(posedge clk) disable iff (rst)
        (iq_v && deq && fire && !redirect) |=> iq_v);

endmodule

// File: rtl/rsp_operand.sv
module rsp_operand
    import rsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iq_v,
    input  instr_t            head,
    input  logic [DATA_W-1:0] rd_val,
    input  logic              drain,
    input  logic              flush,
    output logic              take,
    output logic              stall,
    output logic              oq_v,
    output opnd_t             oq_q
);

    logic room;

    assign stall = iq_v && raw_pending(head, oq_v, oq_q);
    assign room  = !oq_v || drain;
    assign take  = iq_v && !stall && room && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            oq_v <= 1'b0;
            oq_q <= '0;
        end else if (flush) begin
            oq_v <= 1'b0;
        end else if (take) begin
            oq_v <= 1'b1;
            oq_q <= attach_value(head, rd_val);
        end else if (drain) begin
            oq_v <= 1'b0;
        end
    end

    // R8
    oq_refill_chk: assert property (@(posedge clk) disable iff (rst)
        (oq_v && drain && take) |=> oq_v);

endmodule

// File: rtl/rsp_core.sv
module rsp_core
    import rsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    input  logic [IDX_W-1:0]   dbg_sel,
    output logic [DATA_W-1:0]  dbg_val
);

    logic                        iq_v;
    instr_t                      iq_q;
    logic                        oq_v;
    opnd_t                       oq_q;
    logic [PC_W-1:0]             pc;
    logic [DATA_W-1:0]           rd_val;
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic                        op_take;
    logic                        op_stall;
    logic                        do_inc;
    logic                        do_jump;
    logic                        fetch_fire;

    // resolve stage: always consumes whatever the operand queue holds
    assign do_inc     = oq_v && (oq_q.op == OP_INC);
    assign do_jump    = oq_v && (oq_q.op == OP_JZ) && (oq_q.val == '0);
    assign fetch_fire = !iq_v || op_take;
    assign imem_addr  = pc;

    rsp_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .fire     (fetch_fire),
        .deq      (op_take),
        .redirect (do_jump),
        .target   (oq_q.label),
        .word     (imem_data),
        .pc       (pc),
        .iq_v     (iq_v),
        .iq_q     (iq_q)
    );

    rsp_operand u_operand (
        .clk    (clk),
        .rst    (rst),
        .iq_v   (iq_v),
        .head   (iq_q),
        .rd_val (rd_val),
        .drain  (oq_v),
        .flush  (do_jump),
        .take   (op_take),
        .stall  (op_stall),
        .oq_v   (oq_v),
        .oq_q   (oq_q)
    );

    rsp_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (do_inc),
        .wr_idx  (oq_q.idx),
        .wr_val  (oq_q.val + DATA_W'(1)),
        .rd_idx  (iq_q.idx),
        .rd_val  (rd_val),
        .dbg_idx (dbg_sel),
        .dbg_val (dbg_val),
        .regs_o  (regs)
    );

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        do_jump |=> (!iq_v && !oq_v));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        do_jump |=> (pc == $past(oq_q.label)));

    // R4
    inc_writeback_chk: assert property (@(posedge clk) disable iff (rst)
        do_inc |=> (regs[$past(oq_q.idx)] == $past(oq_q.val) + DATA_W'(1)));

    // R5
    raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op_stall |=> (iq_v && $stable(iq_q) && $stable(pc)));

    // R6
    not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (oq_v && oq_q.op == OP_JZ && oq_q.val != '0) |=> $stable(regs));

endmodule

// File: tb/rsp_core_test.sv
module rsp_core_test;
    import rsp_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [PC_W-1:0]    imem_addr;
    logic [INSTR_W-1:0] imem_data;
    logic [IDX_W-1:0]   dbg_sel = '0;
    logic [DATA_W-1:0]  dbg_val;

    logic [INSTR_W-1:0] mem [0:255];
    logic [DATA_W-1:0]  exp_r [0:NREG-1];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign imem_data = mem[imem_addr];

    rsp_core uut (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .dbg_sel   (dbg_sel),
        .dbg_val   (dbg_val)
    );

    // R2 encoding: bit 10 kind (0 inc, 1 jz), bits 9:8 register, bits 7:0 target
    function automatic logic [INSTR_W-1:0] inc_w(int r);
        return {1'b0, 2'(r), 8'h00};
    endfunction

    function automatic logic [INSTR_W-1:0] jz_w(int r, int t);
        return {1'b1, 2'(r), 8'(t)};
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // every unused address parks on a self-loop through r0 (kept at zero)
    task automatic clear_mem();
        for (int a = 0; a < 256; a++) mem[a] = jz_w(0, a);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_reg(int r, output int v);
        dbg_sel = 2'(r);
        #1;
        v = int'(dbg_val);
    endtask

    // sequential reference run of the program in mem
    task automatic ref_run();
        logic [DATA_W-1:0] r [0:NREG-1];
        logic [PC_W-1:0] p;
        logic [INSTR_W-1:0] w;
        for (int i = 0; i < NREG; i++) r[i] = '0;
        p = '0;
        for (int s = 0; s < 20000; s++) begin
            w = mem[p];
            if (w[10] == 1'b0) begin
                r[w[9:8]] = r[w[9:8]] + 8'd1;
                p = p + 8'd1;
            end else if (r[w[9:8]] == 8'd0) begin
                if (w[7:0] == p) break;
                p = w[7:0];
            end else begin
                p = p + 8'd1;
            end
        end
        for (int i = 0; i < NREG; i++) exp_r[i] = r[i];
    endtask

    task automatic compare_regs(string req);
        int v;
        for (int i = 0; i < NREG; i++) begin
            read_reg(i, v);
            chk(req, v, int'(exp_r[i]));
        end
    endtask

    task automatic t_reset();
        int v;
        clear_mem();
        mem[0] = inc_w(1); mem[1] = inc_w(2); mem[2] = inc_w(3);
        do_reset();
        chk("R1 pc after reset", int'(imem_addr), 0);
        step(12);
        do_reset();
        chk("R1 pc after mid-run reset", int'(imem_addr), 0);
        for (int i = 0; i < NREG; i++) begin
            read_reg(i, v);
            chk("R1 R9 register cleared", v, 0);
        end
    endtask

    task automatic t_stream();
        clear_mem();
        mem[0] = inc_w(1); mem[1] = inc_w(2); mem[2] = inc_w(3);
        mem[3] = inc_w(1);
        do_reset();
        step(1);
        chk("R3 address after first fetch", int'(imem_addr), 1);
        step(3);
        chk("R8 full-rate flow address", int'(imem_addr), 4);
        step(20);
        ref_run();
        chk("R4 R10 reference r1", int'(exp_r[1]), 2);
        compare_regs("R10 stream registers");
    endtask

    task automatic t_hazard();
        int v;
        clear_mem();
        mem[0] = inc_w(1); mem[1] = inc_w(1); mem[2] = inc_w(1);
        do_reset();
        step(3);
        chk("R5 fetch held during stall", int'(imem_addr), 2);
        read_reg(1, v);
        chk("R4 first writeback visible", v, 1);
        step(1);
        chk("R5 fetch resumes after stall", int'(imem_addr), 3);
        step(30);
        read_reg(1, v);
        chk("R5 chained increments", v, 3);
    endtask

    task automatic t_not_taken();
        clear_mem();
        mem[0] = inc_w(1); mem[1] = jz_w(1, 10); mem[2] = inc_w(2);
        mem[10] = inc_w(3);
        do_reset();
        step(30);
        ref_run();
        compare_regs("R6 not-taken jump");
    endtask

    task automatic t_taken();
        int v;
        clear_mem();
        mem[0] = jz_w(0, 5); mem[1] = inc_w(1); mem[2] = inc_w(2);
        mem[3] = inc_w(3); mem[5] = inc_w(2);
        do_reset();
        step(2);
        chk("R2 R3 address before redirect", int'(imem_addr), 2);
        step(1);
        chk("R7 redirect to target", int'(imem_addr), 5);
        step(1);
        chk("R7 fetch resumes at target", int'(imem_addr), 6);
        step(20);
        read_reg(1, v);
        chk("R7 shadow r1 discarded", v, 0);
        read_reg(2, v);
        chk("R7 target instruction ran", v, 1);
        read_reg(3, v);
        chk("R7 shadow r3 discarded", v, 0);
    endtask

    task automatic t_loop();
        clear_mem();
        mem[0] = inc_w(1); mem[1] = inc_w(1); mem[2] = inc_w(2);
        mem[3] = jz_w(1, 5); mem[4] = jz_w(0, 0); mem[5] = inc_w(3);
        do_reset();
        step(4000);
        ref_run();
        chk("R4 reference r2 count", int'(exp_r[2]), 128);
        compare_regs("R10 R4 wrap loop");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stream();
        t_hazard();
        t_not_taken();
        t_taken();
        t_loop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule